// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked request interface and an external asynchronous static RAM of 32K bytes. The RAM has active-low select, write and output-enable strobes and one shared data bus. The block accepts one single-byte read or write at a time through a valid/ready handshake. It then plays out the strobe sequence the RAM needs and returns read data with a one-cycle valid pulse.

Every phase length is given in clock cycles. Each is worked out at elaboration from the clock period and the RAM's nanosecond timing figures, rounded up. The data bus is split into an output value, an output enable and an input value, ready for a bidirectional pad. The controller enables its driver only while the RAM's outputs are known to be off. After every read it also leaves a gap so the RAM can release the bus before anything else happens.

Top module: `sram_port_ctrl`

## Requirements
- R1: During and right after reset, select, write enable and output enable are all high, the data driver is off, `reqReady` is high and `rdValid` is low.
- R2: A request is taken on a clock edge where `reqValid` and `reqReady` are both high. `reqReady` then stays low until the access, and any gap after it, has finished. `reqValid` asserted while `reqReady` is low is ignored and causes no RAM access.
- R3: A write lowers select for one setup cycle before write enable falls. Write enable then stays low for the write pulse count, which is 12 cycles at the default settings. Select stays low for one more cycle after write enable rises. Output enable stays high for the whole write.
- R4: The data driver turns on in the second cycle that write enable is low. It stays on until the edge that raises write enable, which also turns it off. While it is on, it drives the byte taken with the request.
- R5: A read holds select and output enable low and write enable high for the access count, which is 14 cycles at the default settings. It samples the RAM data bus on the clock edge that ends the last access cycle.
- R6: `rdValid` is high for exactly one cycle, the cycle right after the access ends. In that cycle `rdData` holds the sampled byte.
- R7: After a read, all strobes are high for the turnaround count, which is 5 cycles at the default settings, before `reqReady` returns high.
- R8: The driver is never on while output enable is low or write enable is high. Write enable is low only while select is low.
- R9: Each phase count is the matching nanosecond figure divided by `CLK_PERIOD_NS`, rounded up. The counts have these floors: setup is at least 1 cycle, and the whole write cycle is at least as long as the write-cycle figure. With a 4 ns clock: write enable is low for at least 40 ns, the driver is on for at least 25 ns before the write ends, and data is sampled no earlier than 55 ns after select and output enable fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Byte address |
| reqWdata | input | 8 | Write byte |
| rdData | output | 8 | Read byte, valid while `rdValid` is high |
| rdValid | output | 1 | One-cycle read-data pulse |
| memAddr | output | 15 | RAM address |
| memCsN | output | 1 | RAM select, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memDqOut | output | 8 | Value driven onto the RAM data bus |
| memDqOe | output | 1 | Data bus driver enable |
| memDqIn | input | 8 | Value seen on the RAM data bus |

## Verification
The properties assume that the request inputs stay stable from the cycle `reqValid` rises until it is accepted. They also assume that `reqValid` never goes unknown after reset. The stimulus changes its inputs only half a cycle away from the active edge. It raises `reqValid` only after it has seen `reqReady` high, except in one deliberate stretch, where it raises `reqValid` during a busy read and keeps it there to show the request is ignored. The RAM model in the bench puts valid data on the bus only after the read strobes have been held for the rated access time. It also stores a byte only at the end of a write whose pulse and data-setup lengths meet the timing rules, so short phases show up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // Strobes passed from the sequencer to the datapath.
  typedef struct packed {
    logic csN;      // registered select level
    logic weN;      // registered write-enable level
    logic oeN;      // registered output-enable level
    logic drive;    // registered data driver enable
    logic load;     // take request address and data this cycle
    logic capture;  // sample the RAM data bus this cycle
  } strobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_AS_NS       = 0,
  parameter int T_WP_NS       = 40,
  parameter int T_WC_NS       = 55,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 30,
  parameter int T_OHZ_NS      = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int SETUP_CYC = maxOf(1, ceilDiv(T_AS_NS, CLK_PERIOD_NS));
  localparam int WP_CYC    = maxOf(2, maxOf(ceilDiv(T_WP_NS, CLK_PERIOD_NS),
                                            ceilDiv(T_WC_NS, CLK_PERIOD_NS) - SETUP_CYC - 1));
  localparam int RD_CYC    = maxOf(1, maxOf(ceilDiv(T_RC_NS, CLK_PERIOD_NS),
                                            maxOf(ceilDiv(T_AA_NS, CLK_PERIOD_NS),
                                                  ceilDiv(T_OE_NS, CLK_PERIOD_NS))));
  localparam int TURN_CYC  = maxOf(1, ceilDiv(T_OHZ_NS, CLK_PERIOD_NS));
  localparam int MAX_CYC   = maxOf(maxOf(SETUP_CYC, WP_CYC), maxOf(RD_CYC, TURN_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACC, ST_RTURN
  } phase_t;

  phase_t           phase, phaseNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic             csQ, weQ, oeQ, drvQ;
  logic             csNx, weNx, oeNx, drvNx;

  always_comb begin
    phaseNx = phase;
    cntNx   = (cnt != '0) ? cnt - 1'b1 : cnt;
    unique case (phase)
      ST_IDLE:
        if (reqValid) begin
          if (reqWrite) begin
            phaseNx = ST_WSETUP;
            cntNx   = CNT_W'(SETUP_CYC - 1);
          end else begin
            phaseNx = ST_RACC;
            cntNx   = CNT_W'(RD_CYC - 1);
          end
        end
      ST_WSETUP:
        if (cnt == '0) begin
          phaseNx = ST_WPULSE;
          cntNx   = CNT_W'(WP_CYC - 1);
        end
      ST_WPULSE:
        if (cnt == '0) begin
          phaseNx = ST_WHOLD;
          cntNx   = '0;
        end
      ST_WHOLD: phaseNx = ST_IDLE;
      ST_RACC:
        if (cnt == '0) begin
          phaseNx = ST_RTURN;
          cntNx   = CNT_W'(TURN_CYC - 1);
        end
      ST_RTURN:
        if (cnt == '0) phaseNx = ST_IDLE;
      default: phaseNx = ST_IDLE;
    endcase
  end

  // Pin levels for the coming cycle, decoded from the next phase.
  always_comb begin
    csNx  = 1'b1;
    weNx  = 1'b1;
    oeNx  = 1'b1;
    drvNx = 1'b0;
    unique case (phaseNx)
      ST_WSETUP, ST_WHOLD: csNx = 1'b0;
      ST_WPULSE: begin
        csNx  = 1'b0;
        weNx  = 1'b0;
        drvNx = (cntNx != CNT_W'(WP_CYC - 1));
      end
      ST_RACC: begin
        csNx = 1'b0;
        oeNx = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      cnt   <= '0;
      csQ   <= 1'b1;
      weQ   <= 1'b1;
      oeQ   <= 1'b1;
      drvQ  <= 1'b0;
    end else begin
      phase <= phaseNx;
      cnt   <= cntNx;
      csQ   <= csNx;
      weQ   <= weNx;
      oeQ   <= oeNx;
      drvQ  <= drvNx;
    end
  end

  assign reqReady     = (phase == ST_IDLE);
  assign strb.csN     = csQ;
  assign strb.weN     = weQ;
  assign strb.oeN     = oeQ;
  assign strb.drive   = drvQ;
  assign strb.load    = (phase == ST_IDLE) && reqValid;
  assign strb.capture = (phase == ST_RACC) && (cnt == '0);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      rdValid <= strb.capture;
      if (strb.capture) rdData <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memCsN   = strb.csN;
  assign memWeN   = strb.weN;
  assign memOeN   = strb.oeN;
  assign memDqOe  = strb.drive;
  assign memDqOut = wdataQ;

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_AS_NS       = 0,
  parameter int T_WP_NS       = 40,
  parameter int T_WC_NS       = 55,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 30,
  parameter int T_OHZ_NS      = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t strb;

  sram_ctrl_seq #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_AS_NS(T_AS_NS), .T_WP_NS(T_WP_NS),
    .T_WC_NS(T_WC_NS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS),
    .T_OE_NS(T_OE_NS), .T_OHZ_NS(T_OHZ_NS)
  ) u_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strb(strb)
  );

  sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdData(rdData), .rdValid(rdValid), .memAddr(memAddr), .memCsN(memCsN),
    .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic rdValid,
  input logic memCsN,
  input logic memWeN,
  input logic memOeN,
  input logic memDqOe
);

  p_drive_safe_r8: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memWeN && memOeN && !memCsN));

  p_we_in_cs_r8: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCsN);

  p_drive_after_we_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> $past(!memWeN));

  p_release_with_we_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> !memDqOe);

  p_cs_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> !memCsN);

  p_oe_high_in_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind sram_port_ctrl sram_port_ctrl_chk u_chk (.*);

// File: tb/sim_sram_port_ctrl.sv
module sim_sram_port_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [14:0] memAddr;
  logic        memCsN, memWeN, memOeN, memDqOe;
  logic [7:0]  memDqOut;
  logic [7:0]  memDqIn = 8'hEE;

  sram_port_ctrl u0 (.*);

  always #2 clk = ~clk;   // 250 MHz

  typedef struct {
    bit cs, we, oe, drv, rdy, rv;
    logic [7:0] dout, rdat;
    string tag;
  } exp_t;

  exp_t expQ[$];
  logic [7:0] ramArr[int];
  logic [7:0] shadow[int];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  function automatic logic [7:0] initPat(input int a);
    return 8'(a) ^ 8'(a >> 7) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ramRd(input int a);
    return ramArr.exists(a) ? ramArr[a] : initPat(a);
  endfunction

  function automatic logic [7:0] shadowRd(input int a);
    return shadow.exists(a) ? shadow[a] : initPat(a);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic exp_t mk(input bit cs, we, oe, drv, rdy, rv,
                              input logic [7:0] dout, rdat, input string tag);
    exp_t e;
    e.cs = cs; e.we = we; e.oe = oe; e.drv = drv; e.rdy = rdy; e.rv = rv;
    e.dout = dout; e.rdat = rdat; e.tag = tag;
    return e;
  endfunction

  // Cycle-by-cycle comparison against the expected strobe sequence
  always @(negedge clk) begin
    exp_t e;
    if (expQ.size() != 0) e = expQ.pop_front();
    else e = mk(1, 1, 1, 0, 1, 0, 8'h00, 8'h00, "R1");
    check(memCsN == e.cs, e.tag, "select", memCsN, e.cs);
    check(memWeN == e.we, e.tag, "write enable", memWeN, e.we);
    check(memOeN == e.oe, e.tag, "output enable", memOeN, e.oe);
    check(memDqOe == e.drv, (e.drv || e.tag == "R3") ? "R4" : e.tag, "driver", memDqOe, e.drv);
    check(reqReady == e.rdy, (e.tag == "R1") ? "R1" : "R2", "ready", reqReady, e.rdy);
    check(rdValid == e.rv, (e.rv || e.tag == "R7") ? "R6" : e.tag, "rdValid", rdValid, e.rv);
    if (e.drv) check(memDqOut == e.dout, "R4", "drive data", memDqOut, e.dout);
    if (e.rv)  check(rdData == e.rdat, "R6", "read data", rdData, e.rdat);
  end

  // RAM model with timing checks
  int readRun = 0, weRun = 0, drvRun = 0;
  bit prevWr = 0;
  logic [7:0]  lastData;
  logic [14:0] lastAddr;
  always @(negedge clk) begin
    bit rdMode, wrAct;
    rdMode = !memCsN && memWeN && !memOeN;
    wrAct  = !memCsN && !memWeN;
    check(!(memDqOe && memWeN && !memOeN), "R8", "bus contention", memDqOe, 0);
    readRun = rdMode ? readRun + 1 : 0;
    memDqIn <= (rdMode && readRun >= 14) ? ramRd(int'(memAddr)) : 8'hEE;
    if (wrAct) begin
      weRun++;
      lastAddr = memAddr;
      if (memDqOe) begin
        drvRun++;
        lastData = memDqOut;
      end
    end
    if (prevWr && !wrAct) begin
      check(weRun >= 10, "R9", "write pulse cycles", weRun, 10);
      check(drvRun >= 7, "R9", "data setup cycles", drvRun, 7);
      if (weRun >= 10 && drvRun >= 7) ramArr[int'(lastAddr)] = lastData;
      weRun = 0;
      drvRun = 0;
    end
    prevWr = wrAct;
  end

  task automatic waitReady();
    forever begin
      @(negedge clk); #1;
      if (reqReady) break;
    end
  endtask

  task automatic doWrite(input logic [14:0] a, input logic [7:0] d);
    waitReady();
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    expQ.push_back(mk(0, 1, 1, 0, 0, 0, d, 0, "R3"));
    expQ.push_back(mk(0, 0, 1, 0, 0, 0, d, 0, "R3"));
    for (int i = 0; i < 11; i++) expQ.push_back(mk(0, 0, 1, 1, 0, 0, d, 0, "R3"));
    expQ.push_back(mk(0, 1, 1, 0, 0, 0, d, 0, "R3"));
    shadow[int'(a)] = d;
    @(negedge clk); #1;
    reqValid = 0;
  endtask

  task automatic doRead(input logic [14:0] a);
    logic [7:0] ev;
    ev = shadowRd(int'(a));
    waitReady();
    reqValid = 1; reqWrite = 0; reqAddr = a; reqWdata = 8'h00;
    for (int i = 0; i < 14; i++) expQ.push_back(mk(0, 1, 0, 0, 0, 0, 0, ev, "R5"));
    expQ.push_back(mk(1, 1, 1, 0, 0, 1, 0, ev, "R7"));
    for (int i = 0; i < 4; i++) expQ.push_back(mk(1, 1, 1, 0, 0, 0, 0, ev, "R7"));
    @(negedge clk); #1;
    reqValid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    repeat (3) @(negedge clk);
    doWrite(15'h0000, 8'hA5);
    doWrite(15'h7FFF, 8'h3C);
    doRead(15'h7FFF);
    doRead(15'h0000);
    doRead(15'h1234);          // never written: initial pattern
    doWrite(15'h2AAA, 8'h00);
    doWrite(15'h2AAA, 8'hFF);  // overwrite
    doRead(15'h2AAA);
    // R2: request raised while busy must be ignored
    doRead(15'h0000);
    repeat (2) @(negedge clk);
    #1 reqValid = 1; reqWrite = 1; reqAddr = 15'h0100; reqWdata = 8'hFF;
    repeat (5) @(negedge clk);
    #1 reqValid = 0;
    doRead(15'h0100);          // R2: must still read the initial pattern
    doWrite(15'h5555, 8'h81);
    doRead(15'h5555);
    repeat (30) @(negedge clk);
    check(expQ.size() == 0, "R2", "pending expectations", expQ.size(), 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) check(0, "R2", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule